// File: doc/BRIEF.md
# Serial Mode-Register Control Port

This block is a four-wire serial slave that gives a host controller read and write access to a small bank of 8-bit mode registers. The registers sit at indexes 16 to 23 of a 7-bit index space. Every transfer is one 16-bit command word. The word carries a direction flag, an index and a data byte, sent most significant bit first. The host drives chip select low, clocks the word in, and returns chip select high before the next word.

The contents of the six writable registers are driven out in parallel to the rest of the design. Two further indexes are read-only. One of them reports a pair of zero-detect flags and the other a 5-bit identifier, both taken from input pins. One bit of the register at index 20 is never stored. Writing a one to it produces a single-cycle reset pulse.

The serial pins are assumed to be already retimed into the system clock domain. The block finds serial clock edges by comparing each sample with the one before.

Top module: `spi_mode_ctrl`

## Requirements
- R1: A command word is 16 bits, sampled on serial clock rising edges, most significant bit first. Bit 15 is the direction (0 = write, 1 = read), bits 14:8 are the register index and bits 7:0 are the data.
- R2: While chip select is high, `spi_miso_oe` is low one system clock after chip select is sampled high. While chip select is low, `spi_miso_oe` is high.
- R3: After reset the register outputs read 0xFF (index 16), 0xFF (17), 0x50 (18, format field bits 6:4 = 101), 0x00 (19), 0x00 (20) and 0x01 (21). `soft_rst_pulse` is low.
- R4: A write changes the indexed register only when the sixteenth rising edge of the word is sampled. The new value is visible on the outputs one system clock later.
- R5: If chip select rises before the sixteenth rising edge, the transfer writes nothing.
- R6: In a read, `spi_miso` stays 0 until the eighth falling edge. After that edge it carries data bit 7 of the indexed register, and each later falling edge moves it to the next lower bit. A read changes no register.
- R7: Index 22 reads {6'b0, zero_flags} and index 23 reads {3'b0, dev_id}. Writes to both indexes are ignored.
- R8: Indexes outside 16 to 23 read as 0x00, and writes to them change no register.
- R9: Reserved bits are not stored and read as 0: bit 3 of index 19, bits 7:6 of index 20, and bits 7:3 of index 21.
- R10: A write to index 20 with bit 6 set raises `soft_rst_pulse` for exactly one system clock. That bit always reads 0.
- R11: Serial clock edges after the sixteenth within one chip-select period are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spi_csn | input | 1 | Chip select, active low, retimed |
| spi_sclk | input | 1 | Serial clock, idles low, retimed |
| spi_mosi | input | 1 | Serial command data in |
| spi_miso | output | 1 | Serial read data out |
| spi_miso_oe | output | 1 | Output enable for spi_miso (high impedance when low) |
| zero_flags | input | 2 | Zero-detect flags reported at index 22 |
| dev_id | input | 5 | Identifier reported at index 23 |
| atten_left | output | 8 | Register at index 16 |
| atten_right | output | 8 | Register at index 17 |
| fmt_ctrl | output | 8 | Register at index 18 |
| out_ctrl | output | 8 | Register at index 19 |
| path_ctrl | output | 8 | Register at index 20 (bit 6 always 0) |
| zero_ctrl | output | 8 | Register at index 21 |
| soft_rst_pulse | output | 1 | One-cycle pulse from writing index 20 bit 6 |

## Verification
A written register changes in the system clock that follows the sampled sixteenth rising edge, and the reset pulse appears in that same clock. The bench therefore checks register outputs only after it has held the serial clock high for several system clocks beyond that edge. Each read bit is valid one system clock after its falling edge is sampled. The bench samples `spi_miso` at the end of each low phase, three clocks after the fall, so every sample lands well after the update and before the next rising edge. The output enable settles one clock after chip select changes, and it is checked only after a wait of at least one low phase.

// File: rtl/spi_mode_pkg.sv
package spi_mode_pkg;
  localparam int WORD_W     = 16;
  localparam int HDR_W      = 8;
  localparam int IDX_W      = 7;
  localparam int DATA_W     = 8;
  localparam int RW_FIRST   = 16;
  localparam int RW_COUNT   = 6;
  localparam int FLAG_IDX   = 22;
  localparam int ID_IDX     = 23;
  localparam int FLAG_W     = 2;
  localparam int ID_W       = 5;
  localparam int PULSE_SLOT = 4;
  localparam int PULSE_BIT  = 6;

  // Reset value of writable slot s (slot 0 is index RW_FIRST).
  function automatic logic [DATA_W-1:0] slot_reset(input int s);
    case (s)
      0, 1:    return 8'hFF;
      2:       return 8'h50;
      5:       return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

  // Bits of slot s that hold state; the pulse bit is not stored.
  function automatic logic [DATA_W-1:0] slot_wmask(input int s);
    case (s)
      3:       return 8'hF7;
      4:       return 8'h3F;
      5:       return 8'h07;
      default: return 8'hFF;
    endcase
  endfunction

  // Value a slot takes when written with d.
  function automatic logic [DATA_W-1:0] slot_update(input int s, input logic [DATA_W-1:0] d);
    return d & slot_wmask(s);
  endfunction
endpackage

// File: rtl/spi_edge_detect.sv
module spi_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic rise,
  output logic fall
);
  logic sig_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sig_q <= 1'b0;
    else        sig_q <= sig;
  end

  assign rise = sig & ~sig_q;
  assign fall = ~sig & sig_q;
endmodule

// File: rtl/spi_word_shifter.sv
module spi_word_shifter #(
  parameter int WORD_W = 16,
  parameter int HDR_W  = 8,
  localparam int CNT_W = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csn,
  input  logic              bit_in,
  input  logic              rise,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              hdr_done,
  output logic [HDR_W-1:0]  hdr_word,
  output logic              word_done,
  output logic [WORD_W-1:0] word_full
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_W - 1);

  logic [WORD_W-2:0] shf_q;
  logic              take;

  assign take      = rise & ~csn & (bit_cnt < CNT_FULL);
  assign hdr_done  = take && (bit_cnt == CNT_HDR);
  assign hdr_word  = {shf_q[HDR_W-2:0], bit_in};
  assign word_done = take && (bit_cnt == CNT_LAST);
  assign word_full = {shf_q, bit_in};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      shf_q   <= '0;
    end else if (csn) begin
      bit_cnt <= '0;
    end else if (take) begin
      shf_q   <= {shf_q[WORD_W-3:0], bit_in};
      bit_cnt <= bit_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/spi_read_shift.sv
module spi_read_shift #(
  parameter int DATA_W = 8,
  parameter int HDR_W  = 8,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csn,
  input  logic              fall,
  input  logic [CNT_W-1:0]  bit_cnt,
  input  logic              rd_req,
  input  logic [DATA_W-1:0] rd_data,
  output logic              miso
);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(HDR_W);

  logic [DATA_W-1:0] tx_q;

  always_ff @(posedge clk) begin
    if (!rst_n || csn) begin
      tx_q <= '0;
    end else if (fall && bit_cnt == CNT_LOAD) begin
      tx_q <= rd_req ? rd_data : '0;
    end else if (fall && bit_cnt > CNT_LOAD) begin
      tx_q <= {tx_q[DATA_W-2:0], 1'b0};
    end
  end

  assign miso = tx_q[DATA_W-1];
endmodule

// File: rtl/mode_reg_bank.sv
module mode_reg_bank
  import spi_mode_pkg::*;
#(
  parameter int BK_DATA_W   = DATA_W,
  parameter int BK_IDX_W    = IDX_W,
  parameter int BK_FIRST    = RW_FIRST,
  parameter int BK_COUNT    = RW_COUNT,
  parameter int BK_FLAG_IDX = FLAG_IDX,
  parameter int BK_ID_IDX   = ID_IDX,
  parameter int BK_FLAG_W   = FLAG_W,
  parameter int BK_ID_W     = ID_W,
  localparam int FLAT_W     = BK_COUNT * BK_DATA_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [BK_IDX_W-1:0]  wr_idx,
  input  logic [BK_DATA_W-1:0] wr_data,
  input  logic [BK_IDX_W-1:0]  rd_idx,
  input  logic [BK_FLAG_W-1:0] zero_flags,
  input  logic [BK_ID_W-1:0]   dev_id,
  output logic [FLAT_W-1:0]    regs_flat,
  output logic [BK_DATA_W-1:0] rd_data,
  output logic                 pulse
);
  localparam logic [BK_IDX_W-1:0] PULSE_IDX = BK_IDX_W'(BK_FIRST + PULSE_SLOT);

  for (genvar k = 0; k < BK_COUNT; k++) begin : g_slot
    logic [BK_DATA_W-1:0] q;
    logic                 hit;
    assign hit = wr_en && (wr_idx == BK_IDX_W'(BK_FIRST + k));
    always_ff @(posedge clk) begin
      if (!rst_n)   q <= slot_reset(k);
      else if (hit) q <= slot_update(k, wr_data);
    end
    assign regs_flat[k*BK_DATA_W +: BK_DATA_W] = q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pulse <= 1'b0;
    else        pulse <= wr_en && (wr_idx == PULSE_IDX) && wr_data[PULSE_BIT];
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < BK_COUNT; k++) begin
      if (rd_idx == BK_IDX_W'(BK_FIRST + k)) rd_data = regs_flat[k*BK_DATA_W +: BK_DATA_W];
    end
    if (rd_idx == BK_IDX_W'(BK_FLAG_IDX)) rd_data = BK_DATA_W'(zero_flags);
    if (rd_idx == BK_IDX_W'(BK_ID_IDX))   rd_data = BK_DATA_W'(dev_id);
  end
endmodule

// File: rtl/spi_mode_ctrl.sv
module spi_mode_ctrl
  import spi_mode_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_csn,
  input  logic              spi_sclk,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  input  logic [FLAG_W-1:0] zero_flags,
  input  logic [ID_W-1:0]   dev_id,
  output logic [DATA_W-1:0] atten_left,
  output logic [DATA_W-1:0] atten_right,
  output logic [DATA_W-1:0] fmt_ctrl,
  output logic [DATA_W-1:0] out_ctrl,
  output logic [DATA_W-1:0] path_ctrl,
  output logic [DATA_W-1:0] zero_ctrl,
  output logic              soft_rst_pulse
);
  localparam int CNT_W = $clog2(WORD_W + 1);

  logic                       sclk_rise, sclk_fall;
  logic [CNT_W-1:0]           bit_cnt;
  logic                       hdr_done, word_done;
  logic [HDR_W-1:0]           hdr_word;
  logic [WORD_W-1:0]          word_full;
  logic                       hdr_rw_q;
  logic [IDX_W-1:0]           hdr_idx_q;
  logic                       wr_commit;
  logic [IDX_W-1:0]           wr_idx;
  logic [DATA_W-1:0]          wr_data;
  logic [DATA_W-1:0]          rd_data;
  logic [RW_COUNT*DATA_W-1:0] regs_flat;

  spi_edge_detect u_sclk_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .sig  (spi_sclk),
    .rise (sclk_rise),
    .fall (sclk_fall)
  );

  spi_word_shifter #(.WORD_W(WORD_W), .HDR_W(HDR_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .csn      (spi_csn),
    .bit_in   (spi_mosi),
    .rise     (sclk_rise),
    .bit_cnt  (bit_cnt),
    .hdr_done (hdr_done),
    .hdr_word (hdr_word),
    .word_done(word_done),
    .word_full(word_full)
  );

  // Header latch: direction and index for the data phase of a read.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hdr_rw_q  <= 1'b0;
      hdr_idx_q <= '0;
    end else if (hdr_done) begin
      hdr_rw_q  <= hdr_word[HDR_W-1];
      hdr_idx_q <= hdr_word[IDX_W-1:0];
    end
  end

  assign wr_commit = word_done & ~word_full[WORD_W-1];
  assign wr_idx    = word_full[DATA_W +: IDX_W];
  assign wr_data   = word_full[DATA_W-1:0];

  mode_reg_bank u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_commit),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .rd_idx    (hdr_idx_q),
    .zero_flags(zero_flags),
    .dev_id    (dev_id),
    .regs_flat (regs_flat),
    .rd_data   (rd_data),
    .pulse     (soft_rst_pulse)
  );

  spi_read_shift #(.DATA_W(DATA_W), .HDR_W(HDR_W), .CNT_W(CNT_W)) u_tx (
    .clk    (clk),
    .rst_n  (rst_n),
    .csn    (spi_csn),
    .fall   (sclk_fall),
    .bit_cnt(bit_cnt),
    .rd_req (hdr_rw_q),
    .rd_data(rd_data),
    .miso   (spi_miso)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) spi_miso_oe <= 1'b0;
    else        spi_miso_oe <= ~spi_csn;
  end

  assign atten_left  = regs_flat[0*DATA_W +: DATA_W];
  assign atten_right = regs_flat[1*DATA_W +: DATA_W];
  assign fmt_ctrl    = regs_flat[2*DATA_W +: DATA_W];
  assign out_ctrl    = regs_flat[3*DATA_W +: DATA_W];
  assign path_ctrl   = regs_flat[4*DATA_W +: DATA_W];
  assign zero_ctrl   = regs_flat[5*DATA_W +: DATA_W];
endmodule

// File: rtl/spi_mode_ctrl_chk.sv
module spi_mode_ctrl_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             csn,
  input logic             miso,
  input logic             miso_oe,
  input logic             wr_commit,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             soft_rst_pulse,
  input logic [7:0]       atten_left,
  input logic [7:0]       atten_right,
  input logic [7:0]       fmt_ctrl,
  input logic [7:0]       out_ctrl,
  input logic [7:0]       path_ctrl,
  input logic [7:0]       zero_ctrl
);
  p_oe_off_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    csn |=> !miso_oe);

  p_no_commit_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    csn |-> !wr_commit);

  p_hold_without_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_commit |=> ($stable(atten_left) && $stable(atten_right) && $stable(fmt_ctrl) &&
                    $stable(out_ctrl) && $stable(path_ctrl) && $stable(zero_ctrl)));

  p_quiet_header_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!csn && bit_cnt < CNT_W'(8)) |-> !miso);

  p_pulse_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_pulse |=> !soft_rst_pulse);

  p_pulse_after_commit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(soft_rst_pulse) |-> $past(wr_commit));
endmodule

bind spi_mode_ctrl spi_mode_ctrl_chk #(.CNT_W(CNT_W)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .csn           (spi_csn),
  .miso          (spi_miso),
  .miso_oe       (spi_miso_oe),
  .wr_commit     (wr_commit),
  .bit_cnt       (bit_cnt),
  .soft_rst_pulse(soft_rst_pulse),
  .atten_left    (atten_left),
  .atten_right   (atten_right),
  .fmt_ctrl      (fmt_ctrl),
  .out_ctrl      (out_ctrl),
  .path_ctrl     (path_ctrl),
  .zero_ctrl     (zero_ctrl)
);

// File: tb/spi_mode_ctrl_tb_top.sv
module spi_mode_ctrl_tb_top;
  localparam int HALF = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       spi_csn = 1'b1, spi_sclk = 1'b0, spi_mosi = 1'b0;
  logic       spi_miso, spi_miso_oe, soft_rst_pulse;
  logic [1:0] zero_flags = 2'b10;
  logic [4:0] dev_id = 5'h15;
  logic [7:0] atten_left, atten_right, fmt_ctrl, out_ctrl, path_ctrl, zero_ctrl;

  always #2 clk = ~clk;

  spi_mode_ctrl dut_i (.*);

  typedef struct {
    logic [7:0] v;
    string      tag;
  } sb_item_t;

  sb_item_t   exp_q[$];
  sb_item_t   obs_q[$];
  int         vectors = 0;
  int         miscompares = 0;
  int         pulse_cycles = 0;
  bit         finished = 0;
  logic [7:0] mdl [6];

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: pairs expected and observed read bytes in order.
  always @(negedge clk) begin
    while (exp_q.size() > 0 && obs_q.size() > 0) begin
      sb_item_t e, o;
      e = exp_q.pop_front();
      o = obs_q.pop_front();
      check(e.tag, o.v, e.v);
    end
  end

  always @(negedge clk) if (rst_n && soft_rst_pulse) pulse_cycles++;

  // Bench model of a write, by slot (index minus 16).
  function automatic void model_write(input int slot, input logic [7:0] d);
    case (slot)
      0, 1, 2: mdl[slot] = d;
      3:       mdl[slot] = {d[7:4], 1'b0, d[2:0]};
      4:       mdl[slot] = {2'b00, d[5:0]};
      5:       mdl[slot] = {5'b0, d[2:0]};
      default: ;
    endcase
  endfunction

  task automatic check_regs(input string req);
    check({req, " idx16"}, atten_left,  mdl[0]);
    check({req, " idx17"}, atten_right, mdl[1]);
    check({req, " idx18"}, fmt_ctrl,    mdl[2]);
    check({req, " idx19"}, out_ctrl,    mdl[3]);
    check({req, " idx20"}, path_ctrl,   mdl[4]);
    check({req, " idx21"}, zero_ctrl,   mdl[5]);
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One chip-select period with nrise serial clock pulses.
  task automatic xfer(input logic rw, input logic [6:0] idx, input logic [7:0] d,
                      input int nrise, output logic [7:0] rd, output bit quiet, output bit oe_on);
    logic [15:0] w;
    w = {rw, idx, d};
    rd = 8'h00; quiet = 1; oe_on = 1;
    @(negedge clk);
    spi_csn = 1'b0;
    wait_clks(HALF);
    for (int k = 0; k < nrise; k++) begin
      spi_mosi = (k < 16) ? w[15-k] : 1'b1;
      wait_clks(HALF);
      if (spi_miso_oe !== 1'b1) oe_on = 0;
      if (k < 8) begin
        if (spi_miso !== 1'b0) quiet = 0;
      end else if (k < 16) begin
        rd[15-k] = spi_miso;
      end
      spi_sclk = 1'b1;
      wait_clks(HALF);
      spi_sclk = 1'b0;
    end
    wait_clks(HALF);
    spi_csn = 1'b1;
    wait_clks(2 * HALF);
  endtask

  task automatic reg_write(input logic [6:0] idx, input logic [7:0] d);
    logic [7:0] rd; bit q, oe;
    xfer(1'b0, idx, d, 16, rd, q, oe);
    if (idx >= 16 && idx <= 21) model_write(int'(idx) - 16, d);
  endtask

  task automatic reg_read(input logic [6:0] idx, input logic [7:0] exp, input string tag);
    logic [7:0] rd; bit q, oe;
    sb_item_t e, o;
    e.v = exp; e.tag = tag;
    exp_q.push_back(e);
    xfer(1'b1, idx, 8'h00, 16, rd, q, oe);
    o.v = rd; o.tag = tag;
    obs_q.push_back(o);
    check({tag, " R6 header quiet"}, {7'b0, q}, 8'h01);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    wait_clks(200000);
    miscompares++;
    $display("FAIL watchdog actual=hung expected=done");
    report();
  end

  initial begin
    logic [7:0] rd; bit q, oe; int p0;
    mdl[0] = 8'hFF; mdl[1] = 8'hFF; mdl[2] = 8'h50;
    mdl[3] = 8'h00; mdl[4] = 8'h00; mdl[5] = 8'h01;
    wait_clks(5);
    rst_n = 1'b1;
    wait_clks(2);

    // R3: reset state
    check_regs("R3 reset");
    check("R3 pulse low", {7'b0, soft_rst_pulse}, 8'h00);
    check("R2 oe idle", {7'b0, spi_miso_oe}, 8'h00);

    // R6/R1: read of reset values
    reg_read(7'd18, 8'h50, "R6 read idx18");
    reg_read(7'd16, 8'hFF, "R6 read idx16");

    // R1/R4: write then read back
    reg_write(7'd16, 8'h3C);
    check_regs("R4 write idx16");
    reg_read(7'd16, 8'h3C, "R1 readback idx16");
    reg_write(7'd18, 8'hA5);
    reg_read(7'd18, 8'hA5, "R1 readback idx18");
    check_regs("R6 read leaves regs");

    // R5: abort after 15 rising edges
    xfer(1'b0, 7'd17, 8'h12, 15, rd, q, oe);
    check_regs("R5 abort");
    check("R2 oe during transfer", {7'b0, oe}, 8'h01);
    check("R2 oe after", {7'b0, spi_miso_oe}, 8'h00);

    // R9: reserved bits
    reg_write(7'd19, 8'hFF);
    reg_write(7'd20, 8'hBF);
    reg_write(7'd21, 8'hFF);
    check_regs("R9 masks");
    reg_read(7'd19, 8'hF7, "R9 read idx19");
    reg_read(7'd21, 8'h07, "R9 read idx21");

    // R10: reset pulse
    p0 = pulse_cycles;
    check("R10 no pulse without bit6", pulse_cycles[7:0], 8'd0);
    reg_write(7'd20, 8'h41);
    check("R10 pulse width", 8'(pulse_cycles - p0), 8'd1);
    check_regs("R10 bit6 not stored");
    reg_read(7'd20, 8'h01, "R10 read idx20");

    // R7: read-only indexes
    reg_read(7'd22, 8'h02, "R7 flags");
    reg_read(7'd23, 8'h15, "R7 id");
    reg_write(7'd22, 8'hFF);
    reg_write(7'd23, 8'hFF);
    check_regs("R7 write ignored");
    zero_flags = 2'b01; dev_id = 5'h0A;
    reg_read(7'd22, 8'h01, "R7 flags live");
    reg_read(7'd23, 8'h0A, "R7 id live");

    // R8: unimplemented indexes
    reg_read(7'd5, 8'h00, "R8 read idx5");
    reg_read(7'd24, 8'h00, "R8 read idx24");
    reg_write(7'd15, 8'h00);
    reg_write(7'h50, 8'h00);
    check_regs("R8 write ignored");

    // R11: extra clocks after the word
    xfer(1'b0, 7'd17, 8'h81, 20, rd, q, oe);
    model_write(1, 8'h81);
    check_regs("R11 extra clocks");

    wait_clks(4);
    check("scoreboard drained", 8'(exp_q.size() + obs_q.size()), 8'd0);
    report();
  end
endmodule